// File: doc/BRIEF.md
# Clock-Recovery Stress Pattern Generator

This block produces an endless serial test pattern for exercising clock-and-data recovery and baseline-wander tolerance in a high-rate receiver. Every repetition has two halves. The first half is a 72-bit zero run, a programmable 31-bit seed, and an excerpt of a maximal-length 2^31-1 pseudo-random sequence that continues from that seed. The second half is the exact bit-for-bit inverse of the first. With the minimum excerpt length, one repetition is 20862 bits.

The pattern leaves the block as W-bit parallel words, one per enabled clock, for a downstream serializer. Repetitions follow each other with no gap, so half and repetition boundaries usually fall inside a word. For the inverted half, the generator reloads the seed and replays the same sequence through an inverter, so no copy of the first half is stored. Seed and excerpt length are sampled only at the first bit of a repetition.

Top module: `cid_pattern_gen`

## Requirements
- R1: While reset is asserted and on the first clock after it, data_o, valid_o, sop_o and half_o are all 0.
- R2: valid_o equals en one clock earlier. A clock with en low emits nothing and advances nothing, so the next enabled word continues exactly where the pattern stopped.
- R3: Every repetition opens with 72 zero bits, followed by the 31 seed bits with seed bit 30 first.
- R4: After the seed, bit n of the pseudo-random stream equals bit n-31 XOR bit n-28, counted over the stream that starts with the seed bits (polynomial x^31 + x^28 + 1).
- R5: The pseudo-random excerpt after the seed is seg_len_i bits long. A value below 10328 is treated as 10328.
- R6: The second half of each repetition is the bitwise inverse of the first half, and the next repetition follows the last bit with no gap.
- R7: An all-zero seed is replaced by all ones, both in the emitted seed bits and as the generator's start state.
- R8: seed_i and seg_len_i are sampled only when the first bit of a repetition is produced. Changes at other times affect only later repetitions.
- R9: Each word carries W consecutive pattern bits, the earliest bit in data_o[W-1]. Boundaries may fall at any bit position inside a word.
- R10: sop_o is 1 exactly on the word that contains the first zero bit of a repetition. half_o is 0 when bit W-1 of the word belongs to the first half and 1 when it belongs to the inverted half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Produce one word on this clock |
| seed_i | input | 31 | Seed for the pseudo-random excerpt |
| seg_len_i | input | LEN_W | Excerpt length in bits |
| data_o | output | W | Pattern word, earliest bit in the MSB |
| valid_o | output | 1 | data_o holds a new word |
| sop_o | output | 1 | Word contains the first bit of a repetition |
| half_o | output | 1 | Half that the word's MSB belongs to |

## Verification
The bench runs the default width of 8 bits. A repetition of 20862 bits is not a multiple of 8, so half and repetition boundaries move to a different bit position in each repetition. A design that mishandles an intra-word boundary would emit a wrong bit or a misplaced sop_o near one of those positions. Seed and length are changed in the middle of a repetition, and a design that applied them at once would change the excerpt before the next start. An all-zero seed is applied to catch an LFSR that locks at zero and a seed field emitted as zeros. A length below the floor is applied to catch an excerpt cut short. A separately stored copy of each first half is compared bit for bit against the second half, which catches a second half that is not a true inverse. The enable is also dropped in mid-pattern, which catches a generator that advances or emits while it is stalled.

// File: rtl/cid_pattern_gen.sv
module cid_pattern_gen #(
  parameter int W        = 8,
  parameter int LEN_W    = 16,
  parameter int ZERO_RUN = 72,
  parameter int MIN_LEN  = 10328
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [30:0]      seed_i,
  input  logic [LEN_W-1:0] seg_len_i,
  output logic [W-1:0]     data_o,
  output logic             valid_o,
  output logic             sop_o,
  output logic             half_o
);
  localparam int SW = 31;
  localparam int PW = $clog2(ZERO_RUN + SW + (1 << LEN_W) + 1);

  logic [PW-1:0]    pos_q, pos_c;
  logic             hf_q, hf_c;
  logic [SW-1:0]    lfsr_q, lfsr_c, seed_q, seed_c;
  logic [LEN_W-1:0] len_q, len_c;
  logic [W-1:0]     word_c;
  logic             sop_c, b;

  always_comb begin
    pos_c  = pos_q;
    hf_c   = hf_q;
    lfsr_c = lfsr_q;
    seed_c = seed_q;
    len_c  = len_q;
    sop_c  = 1'b0;
    word_c = '0;
    b      = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (pos_c == '0) begin
        if (!hf_c) begin
          seed_c = (seed_i == '0) ? '1 : seed_i;
          len_c  = (seg_len_i < LEN_W'(MIN_LEN)) ? LEN_W'(MIN_LEN) : seg_len_i;
          sop_c  = 1'b1;
        end
        lfsr_c = seed_c;
      end
      if (pos_c < PW'(ZERO_RUN)) b = 1'b0;
      else begin
        b      = lfsr_c[SW-1];
        lfsr_c = {lfsr_c[SW-2:0], lfsr_c[SW-1] ^ lfsr_c[SW-4]};
      end
      word_c[i] = b ^ hf_c;
      if (pos_c == PW'(ZERO_RUN + SW - 1) + PW'(len_c)) begin
        pos_c = '0;
        hf_c  = ~hf_c;
      end else pos_c = pos_c + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q   <= '0;
      hf_q    <= 1'b0;
      lfsr_q  <= '1;
      seed_q  <= '1;
      len_q   <= LEN_W'(MIN_LEN);
      data_o  <= '0;
      valid_o <= 1'b0;
      sop_o   <= 1'b0;
      half_o  <= 1'b0;
    end else begin
      valid_o <= en;
      sop_o   <= en && sop_c;
      if (en) begin
        pos_q  <= pos_c;
        hf_q   <= hf_c;
        lfsr_q <= lfsr_c;
        seed_q <= seed_c;
        len_q  <= len_c;
        data_o <= word_c;
        half_o <= hf_q;
      end
    end
  end

  a_r2_valid_on_en: assert property (@(posedge clk) disable iff (rst) en |=> valid_o);
  a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (rst) !en |=> !valid_o && $stable(half_o) && $stable(pos_q));
  a_r5_len_floor: assert property (@(posedge clk) disable iff (rst) len_q >= LEN_W'(MIN_LEN));
  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (rst) lfsr_q != '0 && seed_q != '0);
  a_r8_seed_held: assert property (@(posedge clk) disable iff (rst) !sop_c |=> $stable(seed_q) && $stable(len_q));
  a_r10_sop_valid: assert property (@(posedge clk) disable iff (rst) sop_o |-> valid_o);
  a_r10_sop_single: assert property (@(posedge clk) disable iff (rst) sop_o |=> !sop_o);
endmodule

// File: tb/cid_pattern_gen_test.sv
module cid_pattern_gen_test;
  localparam int W = 8;
  logic clk = 0, rst = 1, en = 0;
  logic [30:0] seed = 31'h1234567;
  logic [15:0] len = 16'd10328;
  logic [W-1:0] data_o;
  logic valid_o, sop_o, half_o;
  int checks = 0, fails = 0;

  int mpos = 0, mlen = 10328;
  bit mhalf = 0;
  logic [30:0] mseed;
  bit hist[$];
  bit first[$];

  cid_pattern_gen uut (.clk(clk), .rst(rst), .en(en), .seed_i(seed), .seg_len_i(len),
                       .data_o(data_o), .valid_o(valid_o), .sop_o(sop_o), .half_o(half_o));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit e);
    logic [W-1:0] ew = '0;
    bit esop = 0, ehalf = mhalf, cbad = 0;
    en = e;
    if (e) begin
      for (int i = W - 1; i >= 0; i--) begin
        bit b, o;
        if (mpos == 0) begin
          if (!mhalf) begin
            mseed = (seed == 0) ? 31'h7fffffff : seed;
            mlen = (len < 10328) ? 10328 : int'(len);
            esop = 1;
            first.delete();
          end
          hist.delete();
          for (int k = 30; k >= 0; k--) hist.push_back(mseed[k]);
        end
        if (mpos < 72) b = 0;
        else begin
          b = hist.pop_front();
          hist.push_back(b ^ hist[2]);
        end
        o = b ^ mhalf;
        ew[i] = o;
        if (!mhalf) first.push_back(o);
        else if (first.size() > 0 && first.pop_front() == o) cbad = 1;
        if (mpos == 72 + 31 + mlen - 1) begin
          mpos = 0;
          mhalf = ~mhalf;
        end else mpos++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(valid_o == e, "R2 valid", valid_o, e);
    if (e) begin
      chk(data_o == ew, "R3/R4/R5/R7/R8/R9 data", data_o, ew);
      chk(sop_o == esop, "R10 sop", sop_o, esop);
      chk(half_o == ehalf, "R10 half", half_o, ehalf);
      chk(!cbad, "R6 complement", cbad, 0);
    end else chk(sop_o == 0, "R2 sop idle", sop_o, 0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data_o == 0 && valid_o == 0 && sop_o == 0 && half_o == 0, "R1 reset", {data_o, valid_o, sop_o, half_o}, 0);
    rst = 0;
    @(posedge clk);
    @(negedge clk);
    chk(valid_o == 0 && sop_o == 0 && half_o == 0, "R1 after reset", {valid_o, sop_o, half_o}, 0);
    repeat (5300) cyc(1);
    seed = 31'h5A5A5A5;
    len = 16'd10400;
    repeat (3000) cyc(1);
    repeat (7) cyc(0);
    repeat (2600) cyc(1);
    seed = 31'h0;
    len = 16'd100;
    repeat (5400) cyc(1);
    repeat (3) cyc(0);
    repeat (20) cyc(1);
    summary();
  end
endmodule